// File: doc/BRIEF.md
# Residue-Channel Four-Tap FIR Filter

This block filters a stream of 3-bit unsigned samples with a fixed four-tap FIR, but it does not use a binary datapath. Each sample is first turned into an integer by adding a small constant for every set bit of the sample. That integer is then split into three residues, modulo 7, 8 and 9. Three independent channels each hold a short history of residues and form the weighted tap sum in their own modular arithmetic, so no carry ever crosses from one channel to another. A reverse stage combines the three channel results with the Chinese remainder theorem and returns a binary value in the range 0 to 503.

The input and output carry one sample per clock with a qualifying valid flag and no back-pressure. The history moves only when a sample is presented, so idle cycles between samples leave the filter state alone. Every stage is registered, which gives a fixed three-cycle delay from input to output.

Top module: `rns_fir_top`

## Requirements
- R1: The integer for a sample is the sum of 3 (bit 0 set), 11 (bit 1 set) and 15 (bit 2 set); sample 7 gives 29, whose residues modulo 7, 8 and 9 are 1, 5 and 2. After reset, the first output for sample s is 8 times this integer.
- R2: For accepted samples x[n], with integers L(x), the output is (8·L(x[n]) + 4·L(x[n-1]) + 2·L(x[n-2]) + 1·L(x[n-3])) mod 504, each channel result lying below its modulus.
- R3: `outValid` is high exactly three clock edges after an edge at which `inValid` was sampled high, and low otherwise.
- R4: Cycles with `inValid` low do not advance the sample history; the tap sum counts accepted samples only.
- R5: `outData` never exceeds 503.
- R6: A synchronous reset clears the whole history to zero (as if sample 0 had been accepted four times), clears `outData` to 0 and drives `outValid` low on the first cycle after reset.
- R7: While `outValid` is low, `outData` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Sample on `inSample` is accepted this cycle |
| inSample | input | 3 | Unsigned input sample |
| outValid | output | 1 | `outData` carries a new result |
| outData | output | 9 | Filter result, 0 to 503 |

## Verification
On every cycle the assertions watch the valid timing, the clearing of the valid flag after reset, that each channel result stays below its modulus, that the output never leaves the 0..503 range, and that the output holds while not valid. The numeric correctness of the tap sum, the bit-to-constant mapping of the forward stage, the tap order, and the fact that idle cycles do not shift the history can only be shown by the bench's scenarios, which compare each result against an integer model: single impulses, long streams, gapped streams and a reset in the middle of a stream.

// File: rtl/rns_fir_pkg.sv
package rns_fir_pkg;

  localparam int N        = 3;
  localparam int NUM_MOD  = 3;
  localparam int TAPS     = 4;
  localparam int IN_W     = 3;
  localparam int RES_W    = $clog2((2 ** N) + 2);
  localparam int DYN      = ((2 ** N) - 1) * (2 ** N) * ((2 ** N) + 1);
  localparam int OUT_W    = $clog2(DYN);
  localparam int CRT_ACC_W = $clog2(DYN * ((2 ** N) + 1) * NUM_MOD);

  // modulus of channel i: 2^N-1, 2^N, 2^N+1
  function automatic int modOf(input int i);
    return (2 ** N) - 1 + i;
  endfunction

  // constant added when sample bit b is set
  function automatic int lutConst(input int b);
    case (b)
      0:       return 3;
      1:       return 11;
      default: return 15;
    endcase
  endfunction

  // tap weight, tap 0 = newest sample
  function automatic int coefOf(input int k);
    return 2 ** (TAPS - 1 - k);
  endfunction

  // CRT weight: (DYN/m) * inverse of (DYN/m) modulo m
  function automatic int crtWeight(input int i);
    int m, big, w;
    m   = modOf(i);
    big = DYN / m;
    w   = 0;
    for (int t = 1; t < m; t++) begin
      if (((big * t) % m) == 1) w = big * t;
    end
    return w;
  endfunction

  typedef struct packed {
    logic fwdLoad;
    logic chanLoad;
    logic crtLoad;
  } strobe_t;

endpackage

// File: rtl/rns_fir_chan.sv
module rns_fir_chan
  import rns_fir_pkg::*;
#(
  parameter int MOD = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [RES_W-1:0] resIn,
  output logic [RES_W-1:0] resOut
);

  logic [RES_W-1:0] line     [TAPS];
  logic [RES_W-1:0] nextLine [TAPS];
  logic [RES_W-1:0] dotMod;

  always_comb begin
    nextLine[0] = resIn;
    for (int k = 1; k < TAPS; k++) nextLine[k] = line[k-1];
  end

  always_comb begin
    int acc;
    acc = 0;
    for (int k = 0; k < TAPS; k++) begin
      acc = (acc + (((coefOf(k) % MOD) * int'(nextLine[k])) % MOD)) % MOD;
    end
    dotMod = RES_W'(acc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < TAPS; k++) line[k] <= '0;
      resOut <= '0;
    end else if (load) begin
      for (int k = 0; k < TAPS; k++) line[k] <= nextLine[k];
      resOut <= dotMod;
    end
  end

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(resOut) < MOD); // R2

endmodule

// File: rtl/rns_fir_ctrl.sv
module rns_fir_ctrl
  import rns_fir_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    inValid,
  output strobe_t stb,
  output logic    outValid
);

  logic v1, v2, v3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      v3 <= 1'b0;
    end else begin
      v1 <= inValid;
      v2 <= v1;
      v3 <= v2;
    end
  end

  always_comb begin
    stb.fwdLoad  = inValid;
    stb.chanLoad = v1;
    stb.crtLoad  = v2;
  end

  assign outValid = v3;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid); // R6

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $past(inValid, 3)); // R3

endmodule

// File: rtl/rns_fir_dp.sv
module rns_fir_dp
  import rns_fir_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          stb,
  input  logic [IN_W-1:0]  sample,
  output logic [OUT_W-1:0] result
);

  logic [RES_W-1:0]     fwdRes  [NUM_MOD];
  logic [RES_W-1:0]     chanRes [NUM_MOD];
  logic [CRT_ACC_W-1:0] crtAcc;
  int                   lutSum;

  // forward conversion: constant per set bit, then residues
  always_comb begin
    lutSum = 0;
    for (int b = 0; b < IN_W; b++) begin
      if (sample[b]) lutSum = lutSum + lutConst(b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_MOD; i++) fwdRes[i] <= '0;
    end else if (stb.fwdLoad) begin
      for (int i = 0; i < NUM_MOD; i++) fwdRes[i] <= RES_W'(lutSum % modOf(i));
    end
  end

  // independent modular channels
  for (genvar gi = 0; gi < NUM_MOD; gi++) begin : g_chan
    rns_fir_chan #(.MOD(modOf(gi))) u_chan (
      .clk    (clk),
      .rst    (rst),
      .load   (stb.chanLoad),
      .resIn  (fwdRes[gi]),
      .resOut (chanRes[gi])
    );
  end

  // reverse conversion by CRT weights
  always_comb begin
    crtAcc = '0;
    for (int i = 0; i < NUM_MOD; i++) begin
      crtAcc = crtAcc + CRT_ACC_W'(chanRes[i]) * CRT_ACC_W'(crtWeight(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
    end else if (stb.crtLoad) begin
      result <= OUT_W'(crtAcc % CRT_ACC_W'(DYN));
    end
  end

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(result) < DYN); // R5

endmodule

// File: rtl/rns_fir_top.sv
module rns_fir_top
  import rns_fir_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inSample,
  output logic             outValid,
  output logic [OUT_W-1:0] outData
);

  strobe_t stb;

  rns_fir_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  rns_fir_dp u_dp (
    .clk    (clk),
    .rst    (rst),
    .stb    (stb),
    .sample (inSample),
    .result (outData)
  );

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> $stable(outData)); // R7

endmodule

// File: tb/sim_rns_fir_top.sv
module sim_rns_fir_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [2:0] inSample = '0;
  logic       outValid;
  logic [8:0] outData;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  int    hist [4];
  bit    pipeV [3];
  int    pipeY [3];
  string pipeTag [3];
  int    lastOut;

  always #2 clk = ~clk;

  rns_fir_top u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outData(outData)
  );

  function automatic int lval(input logic [2:0] s);
    return (s[0] ? 3 : 0) + (s[1] ? 11 : 0) + (s[2] ? 15 : 0);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int k = 0; k < 4; k++) hist[k] = 0;
    for (int k = 0; k < 3; k++) begin pipeV[k] = 0; pipeY[k] = 0; pipeTag[k] = ""; end
    lastOut = 0;
  endtask

  // one clock: drive, advance model, check output of two calls ago
  task automatic step(input bit v, input logic [2:0] s, input string tag);
    int y;
    @(negedge clk);
    inValid  = v;
    inSample = s;
    y = 0;
    if (v) begin
      for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = lval(s);
      y = (8*hist[0] + 4*hist[1] + 2*hist[2] + hist[3]) % 504;
    end
    pipeV[2] = pipeV[1]; pipeY[2] = pipeY[1]; pipeTag[2] = pipeTag[1];
    pipeV[1] = pipeV[0]; pipeY[1] = pipeY[0]; pipeTag[1] = pipeTag[0];
    pipeV[0] = v;        pipeY[0] = y;        pipeTag[0] = tag;
    @(posedge clk);
    #1;
    check("R3 valid timing", int'(outValid), int'(pipeV[2]));
    if (pipeV[2]) begin
      check(pipeTag[2], int'(outData), pipeY[2]);
      check("R5 range", int'(outData < 9'd504), 1);
      lastOut = pipeY[2];
    end else begin
      check("R7 hold", int'(outData), lastOut);
    end
  endtask

  task automatic flush(input string tag);
    for (int k = 0; k < 3; k++) step(1'b0, 3'd0, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; inSample = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    clearModel();
    @(posedge clk);
    #1;
    check("R6 outValid after reset", int'(outValid), 0);
    check("R6 outData after reset", int'(outData), 0);
  endtask

  task automatic testImpulse(input logic [2:0] s);
    doReset();
    step(1'b1, s, "R1 first output");
    for (int k = 0; k < 5; k++) step(1'b0, 3'd0, "R2 impulse");
    for (int k = 0; k < 3; k++) step(1'b1, 3'd0, "R2 impulse tail");
    flush("R2");
  endtask

  task automatic testSeven();
    doReset();
    step(1'b1, 3'd7, "R1 sample 7 gives 232");
    step(1'b1, 3'd0, "R2 tap1 116");
    step(1'b1, 3'd0, "R2 tap2 58");
    step(1'b1, 3'd0, "R2 tap3 29");
    step(1'b1, 3'd0, "R2 flushed 0");
    flush("R2");
    check("R1 model 29", lval(3'd7), 29);
  endtask

  task automatic testStream();
    logic [7:0] lfsr;
    doReset();
    lfsr = 8'hA5;
    for (int k = 0; k < 200; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(1'b1, lfsr[2:0], "R2 stream");
    end
    for (int k = 0; k < 8; k++) step(1'b1, 3'd7, "R2 all sevens");
    flush("R2");
  endtask

  task automatic testGaps();
    logic [7:0] lfsr;
    doReset();
    lfsr = 8'h3C;
    for (int k = 0; k < 150; k++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[7] | lfsr[6], lfsr[2:0], "R4 gapped stream");
    end
    step(1'b1, 3'd5, "R4 before gap");
    for (int k = 0; k < 6; k++) step(1'b0, 3'd7, "R4 idle with data");
    step(1'b1, 3'd1, "R4 after gap");
    flush("R4");
  endtask

  task automatic testMidReset();
    doReset();
    for (int k = 0; k < 6; k++) step(1'b1, 3'(k + 1), "R2 pre-reset");
    doReset();
    step(1'b1, 3'd2, "R6 history cleared");
    step(1'b1, 3'd0, "R6 history cleared");
    flush("R6");
  endtask

  initial begin
    clearModel();
    testSeven();
    testImpulse(3'd1);
    testImpulse(3'd2);
    testImpulse(3'd4);
    testStream();
    testGaps();
    testMidReset();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule